// File: doc/BRIEF.md
# Identifier Area Unlock Sequencer

This block sits behind a serial command decoder and guards a small protected identifier store of 16 bytes. The decoder hands it one decoded command per chip-select frame: a start strobe with the command class, one strobe per complete byte that follows the opcode, and an end strobe when chip-select returns high. The block follows the ordered unlock sequence across frames. After the sequence it opens the identifier store for exactly one write command. It also supplies the byte address of the identifier store for both reads and writes.

The sequence is: a write-enable command, then an unlock command carrying the first key, then an unlock command carrying the second key. Each of these is a frame of its own. A step takes effect only when its frame closes. Anything else that reaches the block in between drops it back to the locked state. When a granted write finishes, the block asks the write-enable latch outside it to clear. It does the same when the command that follows the unlock writes some other memory, and it relocks the area. The serial shifter, the write-enable latch itself and the storage cells lie outside this block.

Top module: `id_unlock_seq`

## Requirements
- R1: The identifier write strobe `id_wr_en` can fire only in a write-ID frame (`cmd_kind` 2) when the three frames before it were, in order: write-enable (`cmd_kind` 0), unlock (`cmd_kind` 1) whose first byte is 0x55, and unlock whose first byte is 0xAA.
- R2: An unlock frame relocks the area when it arrives out of turn, when its first byte is not the key expected at that step, or when it carries no byte.
- R3: Any other frame between the steps relocks the area. This covers a status read, an ID read (`cmd_kind` 3), a memory write (`cmd_kind` 4), codes 5 to 7, and a frame that closes without a command. A write-enable frame always restarts the sequence at its first step.
- R4: The grant covers only the frame immediately after the second key. A second write-ID frame produces no write strobe.
- R5: In an ID read or write frame, the first byte after the opcode loads its low 4 bits into `id_addr`. Each read or write strobe then advances `id_addr` by one, wrapping from 0x0F to 0x00.
- R6: A granted write-ID frame produces at most 8 write strobes, one per data byte. Data bytes beyond the eighth produce no strobe and leave `id_addr` unchanged.
- R7: `wel_clr` is a one-cycle pulse in the cycle after the frame end of a granted write-ID frame, or after the frame end of a memory write that follows the second key. A refused write-ID frame gives no pulse.
- R8: ID reads need no unlock. Every byte slot after the address byte of an ID read frame gives one `id_rd_en` strobe, with no limit on the count.
- R9: After reset the area is locked, `id_addr` is 0 and no strobe or pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Opcode of a new frame decoded |
| cmd_kind | input | 3 | Command class, valid with `cmd_valid` |
| byte_valid | input | 1 | One complete byte after the opcode |
| byte_data | input | 8 | Byte value, valid with `byte_valid` |
| frame_end | input | 1 | Chip-select returned high, frame closed |
| id_wr_en | output | 1 | Write the current data byte to `id_addr` |
| id_rd_en | output | 1 | Read the byte at `id_addr` |
| id_addr | output | 4 | Identifier byte address |
| wel_clr | output | 1 | Request to clear the write-enable latch |

## Verification
Four kinds of command stream are applied. The first is the clean sequence followed by one long write, which shows the eight-byte cap and the address wrap. The second swaps a key, repeats a key, or leaves out the key byte, which separates a check on the key value from a check on its position. The third slips a foreign frame between two steps, such as a status read, an ID read or a memory write, which tells a relocking deviation from one that is let through. The fourth issues a second write after a granted one and an unlocked read starting near the top of the address range, which shows that the grant is used up and that reads wrap without any unlock.

// File: rtl/id_unlock_seq.sv
module id_unlock_seq #(
  parameter int ID_BYTES = 16,
  parameter int PAGE_MAX = 8,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [2:0]                  cmd_kind,
  input  logic                        byte_valid,
  input  logic [7:0]                  byte_data,
  input  logic                        frame_end,
  output logic                        id_wr_en,
  output logic                        id_rd_en,
  output logic [$clog2(ID_BYTES)-1:0] id_addr,
  output logic                        wel_clr
);
  localparam int AW = $clog2(ID_BYTES);
  localparam int CW = $clog2(PAGE_MAX + 1);
  localparam logic [2:0] K_WEN  = 3'd0;
  localparam logic [2:0] K_UNLK = 3'd1;
  localparam logic [2:0] K_IDW  = 3'd2;
  localparam logic [2:0] K_IDR  = 3'd3;
  localparam logic [2:0] K_MEMW = 3'd4;

  typedef enum logic [1:0] {S_LOCK, S_WEN, S_KEYA, S_OPEN} st_t;

  st_t           st, nxt;
  logic [2:0]    kind_q;
  logic          have_cmd, have_b0, grant_q;
  logic [7:0]    key_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] wcnt;

  wire in_data = byte_valid && have_cmd && have_b0;
  assign id_wr_en = in_data && grant_q && (wcnt < CW'(PAGE_MAX));
  assign id_rd_en = in_data && (kind_q == K_IDR);
  assign id_addr  = addr_q;

  always_comb begin
    nxt = S_LOCK;
    if (have_cmd) begin
      case (kind_q)
        K_WEN:  nxt = S_WEN;
        K_UNLK: begin
          if (have_b0 && st == S_WEN && key_q == KEY_A)       nxt = S_KEYA;
          else if (have_b0 && st == S_KEYA && key_q == KEY_B) nxt = S_OPEN;
        end
        default: nxt = S_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_LOCK;
      kind_q   <= 3'd7;
      have_cmd <= 1'b0;
      have_b0  <= 1'b0;
      grant_q  <= 1'b0;
      key_q    <= 8'h00;
      addr_q   <= '0;
      wcnt     <= '0;
      wel_clr  <= 1'b0;
    end else begin
      wel_clr <= 1'b0;
      if (cmd_valid) begin
        kind_q   <= cmd_kind;
        have_cmd <= 1'b1;
        have_b0  <= 1'b0;
        wcnt     <= '0;
        grant_q  <= (cmd_kind == K_IDW) && (st == S_OPEN);
      end else if (byte_valid && have_cmd) begin
        if (!have_b0) begin
          have_b0 <= 1'b1;
          key_q   <= byte_data;
          if (kind_q == K_IDW || kind_q == K_IDR) addr_q <= byte_data[AW-1:0];
        end else if (id_wr_en || id_rd_en) begin
          addr_q <= addr_q + 1'b1;
          if (id_wr_en) wcnt <= wcnt + 1'b1;
        end
      end else if (frame_end) begin
        st       <= nxt;
        have_cmd <= 1'b0;
        grant_q  <= 1'b0;
        wel_clr  <= have_cmd && ((kind_q == K_IDW && grant_q) ||
                                 (kind_q == K_MEMW && st == S_OPEN));
      end
    end
  end

  p_open_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPEN && $past(st) != S_OPEN) |-> $past(st) == S_KEYA);

  p_key_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_KEYA && $past(st) != S_KEYA) |-> $past(st) == S_WEN);

  p_wr_needs_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    id_wr_en |-> st == S_OPEN);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_wr_en || id_rd_en) |=> id_addr == AW'($past(id_addr) + 1'b1));

  p_page_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CW'(PAGE_MAX));

  p_clr_relocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> (st == S_LOCK) ##1 !wel_clr);

  p_one_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_wr_en && id_rd_en));
endmodule

// File: tb/id_unlock_seq_bench.sv
`timescale 1ns/1ps
module id_unlock_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_kind = 3'd0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       frame_end = 1'b0;
  logic       id_wr_en, id_rd_en, wel_clr;
  logic [3:0] id_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int    exp_typ[$];
  int    exp_adr[$];
  string exp_req[$];

  always #2 clk = ~clk;

  id_unlock_seq u_id_unlock_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .byte_valid(byte_valid), .byte_data(byte_data), .frame_end(frame_end),
    .id_wr_en(id_wr_en), .id_rd_en(id_rd_en), .id_addr(id_addr), .wel_clr(wel_clr)
  );

  task automatic expect_ev(input int typ, input int adr, input string req);
    exp_typ.push_back(typ);
    exp_adr.push_back(adr);
    exp_req.push_back(req);
  endtask

  task automatic pop_cmp(input int typ, input int adr);
    int et, ea;
    string er;
    checks++;
    if (exp_typ.size() == 0) begin
      failures++;
      $display("FAIL unexpected event: actual type=%0d addr=%0h expected none", typ, adr);
    end else begin
      et = exp_typ.pop_front();
      ea = exp_adr.pop_front();
      er = exp_req.pop_front();
      if (et != typ || (typ != 3 && ea != adr)) begin
        failures++;
        $display("FAIL %s: actual type=%0d addr=%0h expected type=%0d addr=%0h",
                 er, typ, adr, et, ea);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (id_wr_en) pop_cmp(1, int'(id_addr));
      if (id_rd_en) pop_cmp(2, int'(id_addr));
      if (wel_clr)  pop_cmp(3, 0);
    end
  end

  task automatic drain(input string req);
    repeat (3) @(posedge clk);
    checks++;
    if (exp_typ.size() != 0) begin
      failures++;
      $display("FAIL %s: actual missing events=%0d expected 0 (first type=%0d addr=%0h)",
               req, exp_typ.size(), exp_typ[0], exp_adr[0]);
      exp_typ.delete(); exp_adr.delete(); exp_req.delete();
    end
  endtask

  task automatic frame(input logic [2:0] k, input int nb, input logic [7:0] b0);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_kind = k;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    for (int i = 0; i < nb; i++) begin
      byte_valid = 1'b1;
      byte_data = (i == 0) ? b0 : 8'(i);
      @(posedge clk); #1;
      byte_valid = 1'b0;
    end
    frame_end = 1'b1;
    @(posedge clk); #1;
    frame_end = 1'b0;
    @(posedge clk);
  endtask

  task automatic unlock_all();
    frame(3'd0, 0, 8'h00);
    frame(3'd1, 1, 8'h55);
    frame(3'd1, 1, 8'hAA);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog: actual run still active expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (id_addr !== 4'h0 || id_wr_en !== 1'b0 || id_rd_en !== 1'b0 || wel_clr !== 1'b0) begin
      failures++;
      $display("FAIL R9: actual addr=%0h wr=%b rd=%b clr=%b expected 0 0 0 0",
               id_addr, id_wr_en, id_rd_en, wel_clr);
    end
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R8 R5: locked read from 0x0E wraps to 0x00
    expect_ev(2, 4'hE, "R8"); expect_ev(2, 4'hF, "R8");
    expect_ev(2, 4'h0, "R5"); expect_ev(2, 4'h1, "R5");
    frame(3'd3, 5, 8'h1E);
    drain("R8");

    // R1 R6 R7: clean unlock, 10-byte write from 0x0C, cap at 8
    unlock_all();
    for (int i = 0; i < 8; i++) expect_ev(1, (12 + i) % 16, (i < 4) ? "R1" : "R6");
    expect_ev(3, 0, "R7");
    frame(3'd2, 11, 8'h0C);
    drain("R6");

    // R4: grant used up
    frame(3'd2, 3, 8'h00);
    drain("R4");

    // R2: second key first
    frame(3'd0, 0, 8'h00);
    frame(3'd1, 1, 8'hAA);
    frame(3'd1, 1, 8'hAA);
    frame(3'd2, 3, 8'h00);
    drain("R2");

    // R2: first key repeated
    frame(3'd0, 0, 8'h00);
    frame(3'd1, 1, 8'h55);
    frame(3'd1, 1, 8'h55);
    frame(3'd2, 3, 8'h00);
    drain("R2");

    // R2: unlock frame without byte
    frame(3'd0, 0, 8'h00);
    frame(3'd1, 0, 8'h00);
    frame(3'd1, 1, 8'h55);
    frame(3'd1, 1, 8'hAA);
    frame(3'd2, 3, 8'h00);
    drain("R2");

    // R3: status read between keys
    frame(3'd0, 0, 8'h00);
    frame(3'd1, 1, 8'h55);
    frame(3'd5, 1, 8'h00);
    frame(3'd1, 1, 8'hAA);
    frame(3'd2, 3, 8'h00);
    drain("R3");

    // R3: repeated write-enable restarts, then grant works
    frame(3'd0, 0, 8'h00);
    unlock_all();
    expect_ev(1, 4'h3, "R3"); expect_ev(1, 4'h4, "R3");
    expect_ev(3, 0, "R7");
    frame(3'd2, 3, 8'h03);
    drain("R3");

    // R7: memory write after unlock clears latch and relocks
    unlock_all();
    expect_ev(3, 0, "R7");
    frame(3'd4, 3, 8'h10);
    drain("R7");
    frame(3'd2, 3, 8'h00);
    drain("R7");

    // R3: ID read after unlock relocks without clear
    unlock_all();
    expect_ev(2, 4'h5, "R8"); expect_ev(2, 4'h6, "R8");
    frame(3'd3, 3, 8'h05);
    drain("R3");
    frame(3'd2, 3, 8'h00);
    drain("R3");

    // R3: aborted frame between steps
    frame(3'd0, 0, 8'h00);
    @(posedge clk); #1; frame_end = 1'b1;
    @(posedge clk); #1; frame_end = 1'b0;
    frame(3'd1, 1, 8'h55);
    frame(3'd1, 1, 8'hAA);
    frame(3'd2, 3, 8'h00);
    drain("R3");

    // R8: 20 read slots from 0x00 wrap past 0x0F
    for (int i = 0; i < 20; i++) expect_ev(2, i % 16, "R8");
    frame(3'd3, 21, 8'h00);
    drain("R8");

    finish_run();
  end
endmodule